// File: doc/BRIEF.md
# Parallel Slave Port Controller

This block connects an 8-bit pin group either to general-purpose I/O or to an external bus master that acts on it as a byte-wide slave. The external master uses three active-low strobes: select, read and write. It writes a byte into an input latch, or it reads a byte the CPU has left in an output latch. The CPU side has a small register interface with three addresses. They give access to the port data, a control/status register and a per-bit data direction register.

The control/status register carries the mode bit and the direction bits of the three strobe pins. It also carries three handshake flags that tell the CPU when a byte has arrived, when its outgoing byte has been taken, and when an incoming byte was lost. The strobes and the bus are synchronized into the CPU clock with flip-flop chains. Transfers are taken on the rising (releasing) edge of the write or read strobe while select is low. The bus output enable in slave mode is taken straight from the raw pins so that the master sees the data within the strobe.

Top module: `pslv_port`

## Requirements
- R1: After reset, the control/status register reads 0x07, the direction register reads 0xFF, every bus output enable is 0 and every strobe pin output enable is 0.
- R2: In slave mode, a write transfer by the master stores the bus byte in the input latch and sets the input-full flag (bit 7).
- R3: In slave mode, a CPU read of the data register (address 0) returns the input latch. The same access clears the input-full flag.
- R4: A master write that arrives while the input-full flag is set, and no CPU data read occurs in that cycle, sets the overflow flag (bit 5). The new byte replaces the old one in the input latch.
- R5: The overflow flag stays set until the CPU writes the control register (address 1) with bit 5 at 0. Writing 1 to bit 5 does not change it.
- R6: In slave mode, a CPU write of the data register sets the output-full flag (bit 6). A completed master read transfer clears it.
- R7: In slave mode, the bus is driven with the output latch only while both select and read are low. Otherwise all bus output enables are 0.
- R8: Control register layout: bit 7 input-full, bit 6 output-full, bit 5 overflow, bit 4 mode (1 = slave, 0 = I/O), bit 3 always reads 0, bits 2..0 strobe directions. Bits 7 and 6 ignore CPU writes.
- R9: In I/O mode, each bus output enable is the inverse of its bit in the direction register (address 2, 1 = input), and the driven value is the output latch. A data read returns the bus pins after two synchronizing flops. Strobe activity leaves the flags unchanged.
- R10: The strobe direction bits map bit 0 to read, bit 1 to write and bit 2 to select, with 1 = input. In I/O mode each strobe output enable is the inverse of its direction bit. In slave mode all strobe output enables are 0.
- R11: A write or read strobe edge while select is high is not a transfer: the latches and flags stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 2 | Register select: 0 data, 1 control/status, 2 direction |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_re_i | input | 1 | CPU read strobe |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data (combinational) |
| ext_cs_ni | input | 1 | External select, active low |
| ext_rd_ni | input | 1 | External read strobe, active low |
| ext_wr_ni | input | 1 | External write strobe, active low |
| bus_i | input | 8 | Bus pin levels |
| bus_o | output | 8 | Bus drive value |
| bus_oe_o | output | 8 | Bus output enable per bit |
| strb_oe_o | output | 3 | Strobe pin output enables {select, write, read} |

## Verification
The hardest state to reach is the overflow. It needs a second complete master write, with its full synchronizer latency, to land while the first byte is still unread and no CPU data read falls in that cycle. The stimulus table therefore issues two master writes back to back with no CPU access between them. It then checks that the overflow flag survives a read that drains the latch, and that it also survives a control write carrying 1 in its position. Only a control write with 0 in that position is expected to clear it.

// File: rtl/pslv_pkg.sv
package pslv_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CTRL = 2'd1,
    REG_DDR  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int CtrlW   = 8;
  localparam int BitIbf  = 7;
  localparam int BitObf  = 6;
  localparam int BitOvf  = 5;
  localparam int BitMode = 4;
  localparam int StrbN   = 3;
  // strobe vector order
  localparam int StrbRd  = 0;
  localparam int StrbWr  = 1;
  localparam int StrbCs  = 2;
endpackage

// File: rtl/pslv_sync.sv
module pslv_sync #(
  parameter int          W        = 1,
  parameter int          SYNC_LEN = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] dly_o
);
  localparam int Depth = SYNC_LEN + 1;
  logic [Depth-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= {Depth{RST_VAL}};
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < Depth; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign cur_o = pipe_q[SYNC_LEN-1];
  assign dly_o = pipe_q[SYNC_LEN];
endmodule

// File: rtl/pslv_flags.sv
module pslv_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_evt_i,
  input  logic rd_evt_i,
  input  logic cpu_data_rd_i,
  input  logic cpu_data_wr_i,
  input  logic cpu_ctrl_wr_i,
  input  logic ovf_wbit_i,
  output logic ibf_o,
  output logic obf_o,
  output logic ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ibf_o <= 1'b0;
      obf_o <= 1'b0;
      ovf_o <= 1'b0;
    end else begin
      // arrival wins over a simultaneous drain
      if (wr_evt_i)           ibf_o <= 1'b1;
      else if (cpu_data_rd_i) ibf_o <= 1'b0;

      if (cpu_data_wr_i)      obf_o <= 1'b1;
      else if (rd_evt_i)      obf_o <= 1'b0;

      if (wr_evt_i && ibf_o && !cpu_data_rd_i) ovf_o <= 1'b1;
      else if (cpu_ctrl_wr_i && !ovf_wbit_i)   ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pslv_port.sv
module pslv_port
  import pslv_pkg::*;
#(
  parameter int DW       = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    cpu_addr_i,
  input  logic          cpu_we_i,
  input  logic          cpu_re_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          ext_cs_ni,
  input  logic          ext_rd_ni,
  input  logic          ext_wr_ni,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic [DW-1:0] bus_oe_o,
  output logic [2:0]    strb_oe_o
);
  logic [StrbN-1:0] strb_cur, strb_dly;
  logic [DW-1:0]    bus_cur, bus_dly;
  logic [DW-1:0]    in_q, out_q, ddr_q;
  logic [StrbN-1:0] sdir_q;
  logic             slave_mode;
  logic             ibf, obf, ovf;
  logic             wr_evt, rd_evt;
  logic             data_rd, data_wr, ctrl_wr, ddr_wr;
  logic [CtrlW-1:0] ctrl_rd;
  reg_sel_e         sel;

  pslv_sync #(.W(StrbN), .SYNC_LEN(SYNC_LEN), .RST_VAL({StrbN{1'b1}})) u_strb_sync (
    .clk_i, .rst_ni,
    .d_i   ({ext_cs_ni, ext_wr_ni, ext_rd_ni}),
    .cur_o (strb_cur),
    .dly_o (strb_dly)
  );

  pslv_sync #(.W(DW), .SYNC_LEN(SYNC_LEN), .RST_VAL('0)) u_bus_sync (
    .clk_i, .rst_ni,
    .d_i   (bus_i),
    .cur_o (bus_cur),
    .dly_o (bus_dly)
  );

  // transfer on strobe release while select still low
  assign wr_evt = slave_mode && strb_cur[StrbWr] && !strb_dly[StrbWr] && !strb_dly[StrbCs];
  assign rd_evt = slave_mode && strb_cur[StrbRd] && !strb_dly[StrbRd] && !strb_dly[StrbCs];

  assign sel     = reg_sel_e'(cpu_addr_i);
  assign data_rd = cpu_re_i && sel == REG_DATA && slave_mode;
  assign data_wr = cpu_we_i && sel == REG_DATA;
  assign ctrl_wr = cpu_we_i && sel == REG_CTRL;
  assign ddr_wr  = cpu_we_i && sel == REG_DDR;

  pslv_flags u_flags (
    .clk_i, .rst_ni,
    .wr_evt_i      (wr_evt),
    .rd_evt_i      (rd_evt),
    .cpu_data_rd_i (data_rd),
    .cpu_data_wr_i (data_wr && slave_mode),
    .cpu_ctrl_wr_i (ctrl_wr),
    .ovf_wbit_i    (cpu_wdata_i[BitOvf]),
    .ibf_o         (ibf),
    .obf_o         (obf),
    .ovf_o         (ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q       <= '0;
      out_q      <= '0;
      ddr_q      <= '1;
      sdir_q     <= '1;
      slave_mode <= 1'b0;
    end else begin
      if (wr_evt)  in_q  <= bus_dly;
      if (data_wr) out_q <= cpu_wdata_i;
      if (ddr_wr)  ddr_q <= cpu_wdata_i;
      if (ctrl_wr) begin
        slave_mode <= cpu_wdata_i[BitMode];
        sdir_q     <= cpu_wdata_i[StrbN-1:0];
      end
    end
  end

  assign ctrl_rd = {ibf, obf, ovf, slave_mode, 1'b0, sdir_q};

  always_comb begin
    unique case (sel)
      REG_DATA: cpu_rdata_o = slave_mode ? in_q : bus_cur;
      REG_CTRL: cpu_rdata_o = DW'(ctrl_rd);
      REG_DDR:  cpu_rdata_o = ddr_q;
      default:  cpu_rdata_o = '0;
    endcase
  end

  assign bus_o = out_q;

  for (genvar b = 0; b < DW; b++) begin : g_bus_oe
    assign bus_oe_o[b] = slave_mode ? (!ext_cs_ni && !ext_rd_ni) : !ddr_q[b];
  end

  assign strb_oe_o = slave_mode ? '0 : ~sdir_q;
endmodule

// File: rtl/pslv_checker.sv
module pslv_checker
  import pslv_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    cpu_addr_i,
  input logic          cpu_we_i,
  input logic          cpu_re_i,
  input logic [DW-1:0] cpu_wdata_i,
  input logic [DW-1:0] cpu_rdata_o,
  input logic          ext_cs_ni,
  input logic          ext_rd_ni,
  input logic [DW-1:0] bus_oe_o,
  input logic [2:0]    strb_oe_o,
  input logic          slave_mode,
  input logic          wr_evt,
  input logic          ibf,
  input logic          obf,
  input logic          ovf
);
  p_in_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_evt |=> ibf);

  p_drain_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_re_i && cpu_addr_i == REG_DATA && slave_mode && !wr_evt) |=> !ibf);

  p_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_evt && ibf && !(cpu_re_i && cpu_addr_i == REG_DATA)) |=> ovf);

  p_ovf_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && !(cpu_we_i && cpu_addr_i == REG_CTRL && !cpu_wdata_i[BitOvf])) |=> ovf);

  p_out_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && cpu_addr_i == REG_DATA && slave_mode) |=> obf);

  p_bus_hiz_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_mode && (ext_cs_ni || ext_rd_ni)) |-> bus_oe_o == '0);

  p_bit3_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i == REG_CTRL) |-> !cpu_rdata_o[3]);

  p_strb_in_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_mode |-> strb_oe_o == '0);
endmodule

bind pslv_port pslv_checker #(.DW(DW)) u_pslv_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_re_i    (cpu_re_i),
  .cpu_wdata_i (cpu_wdata_i),
  .cpu_rdata_o (cpu_rdata_o),
  .ext_cs_ni   (ext_cs_ni),
  .ext_rd_ni   (ext_rd_ni),
  .bus_oe_o    (bus_oe_o),
  .strb_oe_o   (strb_oe_o),
  .slave_mode  (slave_mode),
  .wr_evt      (wr_evt),
  .ibf         (ibf),
  .obf         (obf),
  .ovf         (ovf)
);

// File: tb/pslv_port_test.sv
module pslv_port_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] cpu_addr_i = '0;
  logic       cpu_we_i = 1'b0, cpu_re_i = 1'b0;
  logic [7:0] cpu_wdata_i = '0;
  logic [7:0] cpu_rdata_o;
  logic       ext_cs_ni = 1'b1, ext_rd_ni = 1'b1, ext_wr_ni = 1'b1;
  logic [7:0] bus_i = '0;
  logic [7:0] bus_o, bus_oe_o;
  logic [2:0] strb_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pslv_port uut (.*);

  always #4 clk_i = ~clk_i;

  // op: 0 cpu write, 1 cpu read+check, 2 master write, 3 master read+check
  localparam int NV = 19;
  localparam logic [23:0] VECS [NV] = '{
    {4'd2, 2'd0, 2'd1, 8'h10, 8'h00},
    {4'd8, 2'd1, 2'd1, 8'h00, 8'h10},
    {4'd2, 2'd2, 2'd0, 8'hA5, 8'h00},
    {4'd2, 2'd1, 2'd1, 8'h00, 8'h90},
    {4'd3, 2'd1, 2'd0, 8'h00, 8'hA5},
    {4'd3, 2'd1, 2'd1, 8'h00, 8'h10},
    {4'd6, 2'd0, 2'd0, 8'h3C, 8'h00},
    {4'd6, 2'd1, 2'd1, 8'h00, 8'h50},
    {4'd7, 2'd3, 2'd0, 8'h00, 8'h3C},
    {4'd6, 2'd1, 2'd1, 8'h00, 8'h10},
    {4'd4, 2'd2, 2'd0, 8'h11, 8'h00},
    {4'd4, 2'd2, 2'd0, 8'h22, 8'h00},
    {4'd4, 2'd1, 2'd1, 8'h00, 8'hB0},
    {4'd4, 2'd1, 2'd0, 8'h00, 8'h22},
    {4'd5, 2'd1, 2'd1, 8'h00, 8'h30},
    {4'd5, 2'd0, 2'd1, 8'hF0, 8'h00},
    {4'd5, 2'd1, 2'd1, 8'h00, 8'h30},
    {4'd5, 2'd0, 2'd1, 8'h10, 8'h00},
    {4'd5, 2'd1, 2'd1, 8'h00, 8'h10}
  };

  function automatic string req_name(input logic [3:0] n);
    case (n)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_wdata_i = d; cpu_we_i = 1'b1;
    @(negedge clk_i);
    cpu_we_i = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_re_i = 1'b1;
    #1 d = cpu_rdata_o;
    @(negedge clk_i);
    cpu_re_i = 1'b0;
  endtask

  task automatic ext_wr(input logic [7:0] d, input bit selected);
    @(negedge clk_i);
    bus_i = d; ext_cs_ni = !selected; ext_wr_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    ext_wr_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    ext_cs_ni = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic ext_rd(output logic [7:0] d, output logic [7:0] oe);
    @(negedge clk_i);
    ext_cs_ni = 1'b0; ext_rd_ni = 1'b0;
    #1 d = bus_o; oe = bus_oe_o;
    repeat (4) @(negedge clk_i);
    ext_rd_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    ext_cs_ni = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    logic [7:0] rv, oe;
    repeat (3) @(negedge clk_i);
    #1 check("R1", bus_oe_o, 8'h00);
    check("R1", {5'd0, strb_oe_o}, 8'h00);
    rst_ni = 1'b1;
    cpu_rd(2'd1, rv); check("R1", rv, 8'h07);
    cpu_rd(2'd2, rv); check("R1", rv, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq;
      logic [1:0] op, ad;
      logic [7:0] dt, ex;
      {rq, op, ad, dt, ex} = VECS[i];
      case (op)
        2'd0: cpu_wr(ad, dt);
        2'd1: begin cpu_rd(ad, rv); check(req_name(rq), rv, ex); end
        2'd2: ext_wr(dt, 1'b1);
        default: begin
          ext_rd(rv, oe);
          check(req_name(rq), rv, ex);
          check(req_name(rq), oe, 8'hFF);
        end
      endcase
    end

    // R11: strobe without select is not a transfer
    ext_wr(8'h77, 1'b0);
    cpu_rd(2'd1, rv); check("R11", rv, 8'h10);
    cpu_rd(2'd0, rv); check("R11", rv, 8'h22);

    // R7: one of select/read high keeps bus released
    @(negedge clk_i);
    ext_cs_ni = 1'b0; ext_rd_ni = 1'b1;
    #1 check("R7", bus_oe_o, 8'h00);
    @(negedge clk_i);
    ext_cs_ni = 1'b1; ext_rd_ni = 1'b0;
    #1 check("R7", bus_oe_o, 8'h00);
    @(negedge clk_i);
    ext_rd_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R8: bit 3 reads zero
    cpu_wr(2'd1, 8'h0F);
    cpu_rd(2'd1, rv); check("R8", rv, 8'h07);

    // R10: strobe direction mapping and slave override
    cpu_wr(2'd1, 8'h02);
    #1 check("R10", {5'd0, strb_oe_o}, 8'h05);
    cpu_wr(2'd1, 8'h12);
    #1 check("R10", {5'd0, strb_oe_o}, 8'h00);

    // R9: I/O mode
    cpu_wr(2'd1, 8'h07);
    cpu_wr(2'd2, 8'h0F);
    #1 check("R9", bus_oe_o, 8'hF0);
    check("R9", bus_o, 8'h3C);
    bus_i = 8'h5A;
    repeat (4) @(negedge clk_i);
    cpu_rd(2'd0, rv); check("R9", rv, 8'h5A);
    ext_wr(8'h99, 1'b1);
    cpu_rd(2'd1, rv); check("R9", rv, 8'h07);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule